// File: doc/BRIEF.md
# Four-Lane Float Bounds Comparator

This unit checks, for each of four single-precision floating-point lanes, whether a value A lies inside the symmetric range from -B to +B. Each lane returns two direction flags, not a single true/false mask. The high flag means A is above +B. The low flag means A is below -B. A NaN in either operand counts as a breach of both bounds.

All lanes are then reduced to one all-in-range bit. When the caller sets a record flag, that bit is offered as a 4-bit condition field together with a write-enable.

The unit has one registered stage. Inputs are accepted with `valid_in`, and the result, condition field and condition write-enable appear one clock later together with `valid_out`. It raises no exceptions and touches no saturation or carry status.

Top module: `fbc_bounds_cmp`

## Requirements
- R1: Lane i occupies bits [32*i+31:32*i] of `a_in`, `b_in` and `res_out`. In each result lane, bit 31 is the high flag and bit 30 is the low flag.
- R2: The high flag of a lane is set when A[i] > B[i] under IEEE ordering.
- R3: The low flag of a lane is set when A[i] < -B[i]. Here -B[i] is B[i] with its sign bit inverted.
- R4: A NaN is any value with exponent bits 30:23 all ones and a nonzero fraction, quiet or signalling alike. When A[i] or B[i] is a NaN, both flags of that lane are set.
- R5: Bits 29 down to 0 of every result lane are zero.
- R6: +0 and -0 compare equal, so A=-0 with B=+0 sets neither flag. Infinities compare as ordinary ordered values. Denormals are compared by magnitude, with no flushing to zero.
- R7: When `rec_in`=1 with a valid input, `cond_we_out` is 1 in the result cycle. `cond_out` is then {bit3 lt=0, bit2 gt=0, bit1 eq, bit0 so=0}, where eq is 1 only if no flag is set in any lane.
- R8: When `rec_in`=0, `cond_we_out` stays 0 in the result cycle.
- R9: `valid_out`, `res_out`, `cond_out` and `cond_we_out` reflect the inputs accepted at the previous rising edge. A synchronous active-high `rst` clears `valid_out` and `cond_we_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operands and record flag are valid |
| rec_in | input | 1 | Request a condition-field update |
| a_in | input | 128 | Four tested values A |
| b_in | input | 128 | Four bound magnitudes B |
| valid_out | output | 1 | Result valid, one cycle after `valid_in` |
| res_out | output | 128 | Per-lane flag pairs |
| cond_out | output | 4 | Condition field {lt, gt, eq, so} |
| cond_we_out | output | 1 | Condition field write-enable |

## Verification
Every result is due exactly one clock after its operands. The operands are accepted at a rising edge, and `res_out`, `cond_out`, `cond_we_out` and `valid_out` are all registered at that edge. The bench therefore drives operands at a falling edge and samples every output at the next falling edge, which lies halfway past the capturing edge. One falling edge after an idle input, it also confirms that `valid_out` and `cond_we_out` have returned to zero. The sweep pairs every value in a list of zeros, denormals, normals, infinities and NaNs with every other, and the bench computes the expected flags from a signed integer key, not by bit-level comparison.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int LANE_W = 1 + EXP_W + FRAC_W;
  localparam int LANES  = 4;
  localparam int FLAG_HI_BIT = LANE_W - 1;
  localparam int FLAG_LO_BIT = LANE_W - 2;

  typedef logic [LANE_W-1:0] flt_t;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;

  function automatic logic flt_is_nan(input flt_t x);
    return (&x[LANE_W-2:FRAC_W]) && (|x[FRAC_W-1:0]);
  endfunction

  function automatic logic flt_is_zero(input flt_t x);
    return ~|x[LANE_W-2:0];
  endfunction

  function automatic flt_t flt_negate(input flt_t x);
    return {~x[LANE_W-1], x[LANE_W-2:0]};
  endfunction

  // Ordered greater-than for non-NaN operands; signed zeros are equal.
  function automatic logic flt_gt(input flt_t a, input flt_t b);
    logic sa, sb;
    logic [LANE_W-2:0] ma, mb;
    sa = a[LANE_W-1];
    sb = b[LANE_W-1];
    ma = a[LANE_W-2:0];
    mb = b[LANE_W-2:0];
    if (flt_is_zero(a) && flt_is_zero(b)) return 1'b0;
    if (sa != sb) return ~sa;
    if (!sa) return ma > mb;
    return ma < mb;
  endfunction
endpackage

// File: rtl/fbc_lane_cmp.sv
module fbc_lane_cmp
  import fbc_pkg::*;
(
  input  flt_t a_lane,
  input  flt_t b_lane,
  output logic flag_hi,
  output logic flag_lo,
  output logic nan_hit,
  output flt_t lane_res
);
  flt_t neg_b;
  logic above_hi;
  logic below_lo;

  always_comb begin
    neg_b    = flt_negate(b_lane);
    nan_hit  = flt_is_nan(a_lane) | flt_is_nan(b_lane);
    above_hi = flt_gt(a_lane, b_lane);
    below_lo = flt_gt(neg_b, a_lane);
    flag_hi  = nan_hit | above_hi;
    flag_lo  = nan_hit | below_lo;
    lane_res = '0;
    lane_res[FLAG_HI_BIT] = flag_hi;
    lane_res[FLAG_LO_BIT] = flag_lo;
  end
endmodule

// File: rtl/fbc_cond_reduce.sv
module fbc_cond_reduce
  import fbc_pkg::*;
#(
  parameter int N_LANES = 4
) (
  input  logic [N_LANES-1:0] hi_flags,
  input  logic [N_LANES-1:0] lo_flags,
  output logic               all_in,
  output cond_t              cond
);
  always_comb begin
    all_in  = ~(|hi_flags | |lo_flags);
    cond.lt = 1'b0;
    cond.gt = 1'b0;
    cond.eq = all_in;
    cond.so = 1'b0;
  end
endmodule

// File: rtl/fbc_bounds_cmp.sv
module fbc_bounds_cmp
  import fbc_pkg::*;
#(
  parameter int N_LANES = fbc_pkg::LANES
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       valid_in,
  input  logic                       rec_in,
  input  logic [N_LANES*LANE_W-1:0]  a_in,
  input  logic [N_LANES*LANE_W-1:0]  b_in,
  output logic                       valid_out,
  output logic [N_LANES*LANE_W-1:0]  res_out,
  output logic [3:0]                 cond_out,
  output logic                       cond_we_out
);
  localparam int VEC_W = N_LANES * LANE_W;

  logic [N_LANES-1:0] hi_w;
  logic [N_LANES-1:0] lo_w;
  logic [N_LANES-1:0] nan_w;
  logic [VEC_W-1:0]   res_w;
  logic               all_in_w;
  cond_t              cond_w;
  logic               started;

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    fbc_lane_cmp u_lane (
      .a_lane  (a_in[LANE_W*i +: LANE_W]),
      .b_lane  (b_in[LANE_W*i +: LANE_W]),
      .flag_hi (hi_w[i]),
      .flag_lo (lo_w[i]),
      .nan_hit (nan_w[i]),
      .lane_res(res_w[LANE_W*i +: LANE_W])
    );

    // R4: a NaN operand yields both flags in the result cycle
    a_r4_nan_both: assert property (@(posedge clk) disable iff (rst)
      (valid_in && nan_w[i]) |=>
        (res_out[LANE_W*i+FLAG_HI_BIT] && res_out[LANE_W*i+FLAG_LO_BIT]));

    // R5: filler bits of each result lane stay zero
    a_r5_low_zero: assert property (@(posedge clk) disable iff (rst)
      valid_out |-> (res_out[LANE_W*i +: LANE_W-2] == '0));
  end

  fbc_cond_reduce #(.N_LANES(N_LANES)) u_reduce (
    .hi_flags(hi_w),
    .lo_flags(lo_w),
    .all_in  (all_in_w),
    .cond    (cond_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out   <= 1'b0;
      cond_we_out <= 1'b0;
      started     <= 1'b0;
    end else begin
      valid_out   <= valid_in;
      cond_we_out <= valid_in & rec_in;
      started     <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (valid_in) begin
      res_out  <= res_w;
      cond_out <= cond_w;
    end
  end

  // R9: one-cycle latency of the valid strobe
  a_r9_latency: assert property (@(posedge clk) disable iff (rst || !started)
    valid_out == $past(valid_in));

  // R8: no condition write without a record request
  a_r8_no_we: assert property (@(posedge clk) disable iff (rst)
    (valid_in && !rec_in) |=> !cond_we_out);

  // R7: eq bit agrees with the lane flags; other bits clear
  a_r7_eq_agrees: assert property (@(posedge clk) disable iff (rst)
    cond_we_out |-> (valid_out && cond_out[1] == (res_out == '0)
                     && cond_out[3] == 1'b0 && cond_out[2] == 1'b0
                     && cond_out[0] == 1'b0));
endmodule

// File: tb/fbc_bounds_cmp_tb.sv
module fbc_bounds_cmp_tb_top;
  localparam int NV = 14;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         valid_in = 1'b0;
  logic         rec_in = 1'b0;
  logic [127:0] a_in = '0;
  logic [127:0] b_in = '0;
  logic         valid_out;
  logic [127:0] res_out;
  logic [3:0]   cond_out;
  logic         cond_we_out;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  fbc_bounds_cmp dut_i (
    .clk(clk), .rst(rst), .valid_in(valid_in), .rec_in(rec_in),
    .a_in(a_in), .b_in(b_in), .valid_out(valid_out), .res_out(res_out),
    .cond_out(cond_out), .cond_we_out(cond_we_out)
  );

  function automatic logic [31:0] val(input int k);
    case (k)
      0: return 32'h0000_0000;  1: return 32'h8000_0000;
      2: return 32'h3f80_0000;  3: return 32'hbf80_0000;
      4: return 32'h4000_0000;  5: return 32'hc000_0000;
      6: return 32'h0000_0001;  7: return 32'h8000_0001;
      8: return 32'h007f_ffff;  9: return 32'h7f80_0000;
      10: return 32'hff80_0000; 11: return 32'h7fc0_0000;
      12: return 32'h7f80_0001; default: return 32'hff7f_ffff;
    endcase
  endfunction

  function automatic logic nanq(input logic [31:0] x);
    return (x[30:23] == 8'hff) && (x[22:0] != 0);
  endfunction

  // signed integer key that orders floats monotonically, zeros equal
  function automatic longint fkey(input logic [31:0] x);
    longint m;
    m = longint'(x[30:0]);
    return x[31] ? -m : m;
  endfunction

  function automatic logic [31:0] exp_lane(input logic [31:0] a, input logic [31:0] b);
    logic n;
    logic [31:0] r;
    n = nanq(a) | nanq(b);
    r = '0;
    r[31] = n | (fkey(a) > fkey(b));
    r[30] = n | (fkey(a) < -fkey(b));
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [127:0] a, input logic [127:0] b, input logic rec);
    logic [127:0] er;
    logic eq;
    @(negedge clk);
    a_in = a; b_in = b; rec_in = rec; valid_in = 1'b1;
    for (int i = 0; i < 4; i++) er[32*i +: 32] = exp_lane(a[32*i +: 32], b[32*i +: 32]);
    eq = (er == '0);
    @(negedge clk);
    valid_in = 1'b0;
    check("R1 R2 R3 R4 R5 R6 lanes", res_out, er);
    check("R9 valid_out", {127'b0, valid_out}, 128'd1);
    if (rec) begin
      check("R7 cond_we", {127'b0, cond_we_out}, 128'd1);
      check("R7 cond", {124'b0, cond_out}, {124'b0, 1'b0, 1'b0, eq, 1'b0});
    end else begin
      check("R8 cond_we low", {127'b0, cond_we_out}, 128'd0);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] a, b;
    int p;
    repeat (3) @(negedge clk);
    check("R9 reset valid_out", {127'b0, valid_out}, 128'd0);
    check("R9 reset cond_we", {127'b0, cond_we_out}, 128'd0);
    rst = 1'b0;

    // R6 directed: -0 vs +0 in range, all-in-range vector gives eq=1
    apply({32'h8000_0000, 32'h3f80_0000, 32'h0000_0001, 32'h7f80_0000},
          {32'h0000_0000, 32'h4000_0000, 32'h0000_0001, 32'h7f80_0000}, 1'b1);

    // exhaustive pair sweep, four pairs per vector
    p = 0;
    while (p < NV*NV) begin
      for (int l = 0; l < 4; l++) begin
        int q;
        q = (p + l) % (NV*NV);
        a[32*l +: 32] = val(q / NV);
        b[32*l +: 32] = val(q % NV);
      end
      apply(a, b, (p / 4) % 2 == 0);
      p += 4;
    end

    // R9 idle: valid and write-enable drop one cycle after idle input
    @(negedge clk);
    check("R9 idle valid_out", {127'b0, valid_out}, 128'd0);
    check("R8 idle cond_we", {127'b0, cond_we_out}, 128'd0);

    // R9 synchronous reset clears strobes
    @(negedge clk);
    a_in = '0; b_in = '0; rec_in = 1'b1; valid_in = 1'b1; rst = 1'b1;
    @(negedge clk);
    valid_in = 1'b0; rst = 1'b0;
    check("R9 reset mid-run valid_out", {127'b0, valid_out}, 128'd0);
    check("R9 reset mid-run cond_we", {127'b0, cond_we_out}, 128'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule